// File: doc/BRIEF.md
# Debug abstract command controller

This block takes abstract register-access commands from an external debugger through a simple register port. A 32-bit command word is decoded and validated: the command type, the register number, the access size and whether the selected hart is halted. When all checks pass, the block produces two instruction words for the hart to fetch and marks itself busy until a completion pulse arrives. The first word is a load or store between a general-purpose register and a fixed data exchange window. The second word is either a jump into the program buffer or an `ebreak`.

The block also holds the data exchange words and the program buffer words, a sticky error code and one auto-execute bit per data word. When an auto-execute bit is set, any read or write of the matching data word launches the most recent command again. A fetch monitor outside the block serves the generated words to the hart and pulses `exec_done` when the command has finished. Register offsets on the port are: data words from 0x04, status at 0x16, command at 0x17 and program buffer words from 0x20.

Top module: `dbg_abscmd_ctrl`

## Requirements
- R1: After reset, `busy`, `launch` and `cmderr` are 0. Status bits 3:0 read back the number of data words, which is the exchange size in bytes divided by 4 (2 by default).
- R2: A command is accepted when all of the following hold: bits 31:24 are 0, bits 15:0 lie in 0x1000..0x101F, `hart_halted` is 1, and size bits 22:20 are 2 or 3. The write of such a command raises `launch` for exactly the one cycle after the write edge and sets `busy`. `cmderr` stays 0.
- R3: For an accepted command, `insn0` is a load `{EXCH_OFS, x0, f3, rd, 0000011}` when bit 16 is 1, and a store `{EXCH_OFS[11:5], rs2, x0, f3, EXCH_OFS[4:0], 0100011}` when bit 16 is 0. The register is bits 4:0 of the register number. `f3` is 010 for size 2 and 011 for size 3.
- R4: For an accepted command, `insn1` is `jal x0, PBUF_JUMP` when bit 18 is 1 and `ebreak` (0x00100073) when bit 18 is 0.
- R5: Any of the following sets `cmderr` to 2 (not supported), with no launch and no change to `busy`: a nonzero type, a register number outside 0x1000..0x101F, or a size other than 2 or 3. The type is checked first, then the register range, then the halt state, then the size.
- R6: A command that is otherwise valid but arrives while `hart_halted` is 0 sets `cmderr` to 4 (halt/resume).
- R7: A command that arrives while `busy` is set makes `cmderr` 1 (busy). A command that arrives while `cmderr` is nonzero is ignored: no launch, and the error code is unchanged.
- R8: Reading or writing a data word while `busy` is set and `cmderr` is 0 sets `cmderr` to 1. Data writes are always stored and read back unchanged.
- R9: Status bits 16+i hold the auto-execute bit of data word i. While the bit is set, a read or write of data word i relaunches the last written command. Accessing a word whose bit is clear launches nothing.
- R10: `cmderr` changes back to 0 only on a status write whose bits 10:8 are 0. A status write with a nonzero value there leaves the code as it is. Status bits 10:8 read the code and bit 12 reads `busy`.
- R11: An `exec_done` pulse while busy clears `busy` on the next edge.
- R12: Program buffer words are written and read back at offsets 0x20 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current offset (combinational) |
| hart_halted | input | 1 | The selected hart is halted |
| exec_done | input | 1 | Completion pulse from the fetch monitor |
| insn0 | output | 32 | First generated instruction (load or store) |
| insn1 | output | 32 | Second generated instruction (jump or ebreak) |
| launch | output | 1 | One-cycle pulse when a command is issued |
| busy | output | 1 | A command is in flight |
| cmderr | output | 3 | Sticky error code: 0 none, 1 busy, 2 not supported, 3 exception, 4 halt/resume |

## Verification
The assertions take three things for granted. `exec_done` is pulsed only while `busy` is set. It never falls on the same edge as a command or data access. `hart_halted` does not change on the edge where a command is written. The bench raises `exec_done` only after it has seen a launch, and always on a cycle with no access. It also sets `hart_halted` several cycles before it writes each command.

// File: rtl/dbg_abscmd_ctrl.sv
module dbg_abscmd_ctrl #(
  parameter int          EXCH_BYTES = 8,
  parameter int          PBUF_WORDS = 4,
  parameter logic [11:0] EXCH_OFS   = 12'h380,
  parameter logic [20:0] PBUF_JUMP  = 21'h000100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [6:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  input  logic        hart_halted,
  input  logic        exec_done,
  output logic [31:0] insn0,
  output logic [31:0] insn1,
  output logic        launch,
  output logic        busy,
  output logic [2:0]  cmderr
);
  localparam int DATA_WORDS = EXCH_BYTES / 4;
  localparam int DIW = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
  localparam int PIW = (PBUF_WORDS > 1) ? $clog2(PBUF_WORDS) : 1;
  localparam logic [6:0] A_DATA0  = 7'h04;
  localparam logic [6:0] A_DATAE  = A_DATA0 + 7'(DATA_WORDS);
  localparam logic [6:0] A_STATUS = 7'h16;
  localparam logic [6:0] A_CMD    = 7'h17;
  localparam logic [6:0] A_PBUF0  = 7'h20;
  localparam logic [6:0] A_PBUFE  = A_PBUF0 + 7'(PBUF_WORDS);
  localparam logic [2:0] E_NONE = 3'd0, E_BUSY = 3'd1, E_NOTSUP = 3'd2, E_HALT = 3'd4;
  localparam logic [31:0] EBREAK = 32'h0010_0073;

  logic [31:0] data_q [DATA_WORDS];
  logic [31:0] pbuf_q [PBUF_WORDS];
  logic [31:0] cmd_q;
  logic [DATA_WORDS-1:0] ae_q;
  logic [2:0]  err_q, err_nx;
  logic        busy_q, go, launch_q;
  logic [31:0] insn0_q, insn1_q;

  logic [6:0] data_off, pbuf_off;
  logic [DIW-1:0] didx;
  logic [PIW-1:0] pidx;
  assign data_off = req_addr - A_DATA0;
  assign pbuf_off = req_addr - A_PBUF0;
  assign didx = data_off[DIW-1:0];
  assign pidx = pbuf_off[PIW-1:0];

  logic data_hit, pbuf_hit, cmd_wr, st_wr, err_clr, try_cmd;
  assign data_hit = req_valid && req_addr >= A_DATA0 && req_addr < A_DATAE;
  assign pbuf_hit = req_valid && req_addr >= A_PBUF0 && req_addr < A_PBUFE;
  assign cmd_wr   = req_valid && req_write && req_addr == A_CMD;
  assign st_wr    = req_valid && req_write && req_addr == A_STATUS;
  assign err_clr  = st_wr && req_wdata[10:8] == E_NONE;
  assign try_cmd  = cmd_wr || (data_hit && ae_q[didx]);

  logic [31:0] cw;
  assign cw = cmd_wr ? req_wdata : cmd_q;

  logic [2:0] csize;
  logic [4:0] creg;
  logic [2:0] f3;
  logic       reg_ok, size_ok;
  assign csize   = cw[22:20];
  assign creg    = cw[4:0];
  assign f3      = (csize == 3'd3) ? 3'b011 : 3'b010;
  assign reg_ok  = cw[15:0] >= 16'h1000 && cw[15:0] <= 16'h101F;
  assign size_ok = csize == 3'd2 || csize == 3'd3;

  always_comb begin
    err_nx = err_q;
    go     = 1'b0;
    if (data_hit && busy_q && err_q == E_NONE) err_nx = E_BUSY;
    if (try_cmd && err_nx == E_NONE) begin
      if (busy_q)                err_nx = E_BUSY;
      else if (cw[31:24] != 8'd0) err_nx = E_NOTSUP;
      else if (!reg_ok)          err_nx = E_NOTSUP;
      else if (!hart_halted)     err_nx = E_HALT;
      else if (!size_ok)         err_nx = E_NOTSUP;
      else                       go = 1'b1;
    end
    if (err_clr) err_nx = E_NONE;
  end

  logic [31:0] ld_w, st_w, jal_w;
  assign ld_w  = {EXCH_OFS, 5'd0, f3, creg, 7'b0000011};
  assign st_w  = {EXCH_OFS[11:5], creg, 5'd0, f3, EXCH_OFS[4:0], 7'b0100011};
  assign jal_w = {PBUF_JUMP[20], PBUF_JUMP[10:1], PBUF_JUMP[11], PBUF_JUMP[19:12],
                  5'd0, 7'b1101111};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= E_NONE;
      busy_q   <= 1'b0;
      launch_q <= 1'b0;
      cmd_q    <= '0;
      ae_q     <= '0;
      insn0_q  <= 32'h0000_006f;
      insn1_q  <= EBREAK;
    end else begin
      err_q    <= err_nx;
      launch_q <= go;
      if (go) begin
        busy_q  <= 1'b1;
        insn0_q <= cw[16] ? ld_w : st_w;
        insn1_q <= cw[18] ? jal_w : EBREAK;
      end else if (exec_done) begin
        busy_q <= 1'b0;
      end
      if (cmd_wr) cmd_q <= req_wdata;
      if (st_wr)  ae_q  <= req_wdata[16 +: DATA_WORDS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_WORDS; i++) data_q[i] <= '0;
      for (int i = 0; i < PBUF_WORDS; i++) pbuf_q[i] <= '0;
    end else if (req_write) begin
      if (data_hit) data_q[didx] <= req_wdata;
      if (pbuf_hit) pbuf_q[pidx] <= req_wdata;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (data_hit)                 rsp_rdata = data_q[didx];
    else if (pbuf_hit)            rsp_rdata = pbuf_q[pidx];
    else if (req_addr == A_CMD)   rsp_rdata = cmd_q;
    else if (req_addr == A_STATUS) begin
      rsp_rdata[3:0]             = 4'(DATA_WORDS);
      rsp_rdata[10:8]            = err_q;
      rsp_rdata[12]              = busy_q;
      rsp_rdata[16 +: DATA_WORDS] = ae_q;
    end
  end

  assign insn0  = insn0_q;
  assign insn1  = insn1_q;
  assign launch = launch_q;
  assign busy   = busy_q;
  assign cmderr = err_q;

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> busy) else $error("launch without busy"); // R2
  AST_BUSY_RISE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> launch) else $error("busy without launch"); // R2
  AST_LAUNCH_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(hart_halted)) else $error("launch while running"); // R6
  AST_LAUNCH_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> cmderr == E_NONE) else $error("launch with error"); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmderr != E_NONE && !err_clr) |=> $stable(cmderr)) else $error("error not sticky"); // R10
  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmderr <= 3'd4) else $error("illegal error code"); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exec_done && !req_valid) |=> !busy) else $error("busy stuck"); // R11
endmodule

// File: tb/tb_dbg_abscmd_ctrl.sv
module tb_dbg_abscmd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata, insn0, insn1;
  logic hart_halted = 1'b0, exec_done = 1'b0;
  logic launch, busy;
  logic [2:0] cmderr;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbg_abscmd_ctrl dut (.*);

  localparam logic [6:0] A_D0 = 7'h04, A_ST = 7'h16, A_CMD = 7'h17, A_PB = 7'h20;
  localparam logic [11:0] XOFS = 12'h380;
  localparam logic [20:0] PJ = 21'h000100;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    #1 d = rsp_rdata;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); exec_done = 1;
    @(negedge clk); exec_done = 0;
  endtask

  function automatic logic [31:0] mk_cmd(logic [7:0] ty, logic [2:0] sz, bit post, bit wrb, logic [15:0] rn);
    return {ty, 1'b0, sz, 1'b0, post, 1'b0, wrb, rn};
  endfunction

  function automatic logic [31:0] e_load(logic [4:0] r, logic [2:0] f);
    return {XOFS, 5'd0, f, r, 7'h03};
  endfunction
  function automatic logic [31:0] e_store(logic [4:0] r, logic [2:0] f);
    return {XOFS[11:5], r, 5'd0, f, XOFS[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] e_jal();
    return {PJ[20], PJ[10:1], PJ[11], PJ[19:12], 5'd0, 7'h6f};
  endfunction

  task automatic clear_err();
    wr(A_ST, 32'h0);
    chk("R10 cleared", {29'd0, cmderr}, 0);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 launch", {31'd0, launch}, 0);
    chk("R1 err", {29'd0, cmderr}, 0);
    rd(A_ST, s);
    chk("R1 datacount", {28'd0, s[3:0]}, 2);
  endtask

  task automatic t_load32();
    wr(A_CMD, mk_cmd(8'd0, 3'd2, 0, 1, 16'h1005));
    chk("R2 launch", {31'd0, launch}, 1);
    chk("R2 busy", {31'd0, busy}, 1);
    chk("R2 err", {29'd0, cmderr}, 0);
    chk("R3 lw", insn0, e_load(5'd5, 3'b010));
    chk("R4 ebreak", insn1, 32'h00100073);
    @(negedge clk);
    chk("R2 launch pulse one cycle", {31'd0, launch}, 0);
    done_pulse();
    chk("R11 busy cleared", {31'd0, busy}, 0);
  endtask

  task automatic t_store64_post();
    wr(A_CMD, mk_cmd(8'd0, 3'd3, 1, 0, 16'h101F));
    chk("R2 launch 64", {31'd0, launch}, 1);
    chk("R3 sd", insn0, e_store(5'd31, 3'b011));
    chk("R4 jal", insn1, e_jal());
    done_pulse();
    wr(A_CMD, mk_cmd(8'd0, 3'd3, 0, 1, 16'h1000));
    chk("R3 ld x0", insn0, e_load(5'd0, 3'b011));
    done_pulse();
  endtask

  task automatic t_notsup();
    wr(A_CMD, mk_cmd(8'd1, 3'd2, 0, 1, 16'h1001));
    chk("R5 type launch", {31'd0, launch}, 0);
    chk("R5 type err", {29'd0, cmderr}, 2);
    wr(A_ST, 32'h0000_0300);
    chk("R10 nonzero write keeps", {29'd0, cmderr}, 2);
    clear_err();
    wr(A_CMD, mk_cmd(8'd0, 3'd2, 0, 1, 16'h1020));
    chk("R5 regno high", {29'd0, cmderr}, 2);
    clear_err();
    wr(A_CMD, mk_cmd(8'd0, 3'd2, 0, 1, 16'h0FFF));
    chk("R5 regno low", {29'd0, cmderr}, 2);
    clear_err();
    wr(A_CMD, mk_cmd(8'd0, 3'd4, 0, 1, 16'h1002));
    chk("R5 size", {29'd0, cmderr}, 2);
    chk("R5 busy unchanged", {31'd0, busy}, 0);
    clear_err();
  endtask

  task automatic t_halt();
    hart_halted = 0;
    repeat (2) @(negedge clk);
    wr(A_CMD, mk_cmd(8'd0, 3'd2, 0, 1, 16'h1003));
    chk("R6 halt err", {29'd0, cmderr}, 4);
    chk("R6 no launch", {31'd0, launch}, 0);
    clear_err();
    wr(A_CMD, mk_cmd(8'd0, 3'd4, 0, 1, 16'h2000));
    chk("R5 range before halt", {29'd0, cmderr}, 2);
    clear_err();
    hart_halted = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(A_CMD, mk_cmd(8'd0, 3'd2, 0, 1, 16'h1004));
    chk("R7 first launch", {31'd0, launch}, 1);
    wr(A_CMD, mk_cmd(8'd0, 3'd2, 0, 0, 16'h1006));
    chk("R7 busy err", {29'd0, cmderr}, 1);
    chk("R7 no relaunch", {31'd0, launch}, 0);
    chk("R7 insn kept", insn0, e_load(5'd4, 3'b010));
    clear_err();
    wr(A_D0 + 7'd1, 32'hCAFE_0001);
    chk("R8 data busy err", {29'd0, cmderr}, 1);
    rd(A_D0 + 7'd1, v);
    chk("R8 data stored", v, 32'hCAFE_0001);
    clear_err();
    done_pulse();
    wr(A_D0, 32'h1234_5678);
    chk("R8 no err when idle", {29'd0, cmderr}, 0);
    rd(A_D0, v);
    chk("R8 readback", v, 32'h1234_5678);
  endtask

  task automatic t_err_blocks();
    wr(A_CMD, mk_cmd(8'd2, 3'd2, 0, 1, 16'h1001));
    chk("R5 setup", {29'd0, cmderr}, 2);
    wr(A_CMD, mk_cmd(8'd0, 3'd2, 0, 1, 16'h1001));
    chk("R7 ignored launch", {31'd0, launch}, 0);
    chk("R7 ignored err", {29'd0, cmderr}, 2);
    chk("R7 ignored busy", {31'd0, busy}, 0);
    clear_err();
  endtask

  task automatic t_autoexec();
    logic [31:0] v, s;
    wr(A_ST, 32'h0002_0000);
    rd(A_ST, s);
    chk("R9 ae readback", {31'd0, s[17]}, 1);
    wr(A_CMD, mk_cmd(8'd0, 3'd2, 1, 1, 16'h1007));
    chk("R9 initial", {31'd0, launch}, 1);
    done_pulse();
    wr(A_D0 + 7'd1, 32'h5);
    chk("R9 write relaunch", {31'd0, launch}, 1);
    chk("R9 same insn", insn0, e_load(5'd7, 3'b010));
    done_pulse();
    rd(A_D0, v);
    chk("R9 word0 no launch", {31'd0, launch}, 0);
    rd(A_D0 + 7'd1, v);
    chk("R9 read relaunch", {31'd0, launch}, 1);
    done_pulse();
    wr(A_ST, 32'h0);
  endtask

  task automatic t_pbuf();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) wr(A_PB + 7'(i), 32'hA000_0000 + i);
    for (int i = 0; i < 4; i++) begin
      rd(A_PB + 7'(i), v);
      chk("R12 progbuf", v, 32'hA000_0000 + i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    hart_halted = 1;
    repeat (2) @(negedge clk);
    t_load32();
    t_store64_post();
    t_notsup();
    t_halt();
    t_busy();
    t_err_blocks();
    t_autoexec();
    t_pbuf();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule